// File: doc/BRIEF.md
# Single-Slope PWM Timer with Selectable Period End

This block is a 16-bit up-counting timer that drives pulse-width-modulated outputs with a single ramp per period. The count climbs by one on every cycle where the timer clock enable is high. It returns to zero on the enabled tick after it equals the period end value, called TOP.

TOP comes from one of five sources, chosen by a 4-bit mode code:
- three fixed widths of 8, 9 and 10 bits;
- a period register that has no buffer, so a write takes effect at once;
- the active value of compare channel A. That value is buffered and is reloaded when the counter reaches TOP.

Each compare channel holds a written value in a buffer until TOP, then uses it as the active value. Each channel drives one output pin in a non-inverted mode, an inverted mode or a disconnected mode. The block keeps a set of sticky event flags: overflow, period match and one compare match per channel. A flag is cleared by writing a one to its bit in the clear vector.

Software writes the period register and the compare buffers through a simple address/data strobe. Writes are not gated by the timer clock enable.

Top module: `pwm_slope_timer`

## Requirements
- R1: The mode code selects TOP: 5 gives 0x00FF, 6 gives 0x01FF, 7 gives 0x03FF, 14 gives the period register, 15 gives the active compare value of channel A. In steady state one period lasts TOP+1 enabled ticks.
- R2: On a tick with `tick_en` high, the count increments by one, or becomes zero when it equals TOP. With `tick_en` low, the count and every flag hold.
- R3: `flags[0]` (overflow) is set on the tick where the count equals TOP. In mode 14, `flags[1]` (period match) is set on that same tick. In mode 15, the channel A compare flag is set on that same tick.
- R4: A period register write (address 0) changes TOP in the next cycle. If the count is already above the new value, it runs to 0xFFFF and wraps to zero, and no overflow flag is set at that wrap.
- R5: A compare write (address 1+k for channel k) goes into a buffer. The buffer moves into the active compare value only on the tick where the count equals TOP.
- R6: In modes 5, 6 and 7, compare bits above the active resolution are forced to zero when the value is written.
- R7: The flag of channel k, `flags[2+k]`, is set on a tick where the count equals that channel's active compare value. An active compare value above TOP never sets it.
- R8: Output mode 2 (non-inverted) drives the pin high from BOTTOM and low after a compare match, so it is high for min(compare, TOP)+1 ticks per period. Mode 3 drives the complement of that waveform. Modes 0 and 1 hold the pin low.
- R9: Writing a one to a bit of `flag_clr` clears that flag and leaves the others unchanged. A set event in the same cycle wins over the clear.
- R10: Reset clears the count, all flags, all outputs, the period register and the compare values. Reset asserts asynchronously and releases after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer clock enable, one tick per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | 0 selects the period register, 1+k selects compare channel k |
| wr_data | input | 16 | Write data |
| mode_sel | input | 4 | TOP source code (5, 6, 7, 14, 15) |
| out_mode | input | 2*NCH | Two bits per channel: 2 non-inverted, 3 inverted, otherwise low |
| flag_clr | input | NCH+2 | Write-one-to-clear, same layout as `flags` |
| count_out | output | 16 | Current counter value |
| flags | output | NCH+2 | Bit 0 overflow, bit 1 period match, bit 2+k compare match of channel k |
| pwm_out | output | NCH | PWM output pins, one per channel |

## Verification
Properties are checked on every cycle:
- The counter steps by one, wraps after TOP and holds without an enable.
- The overflow flag, and in modes 14 and 15 the flag that goes with it, is raised together with the wrap.
- An active compare value moves only at TOP.
- A write in a fixed mode leaves no bit above the resolution.
- Flags set and clear as the set and clear vectors say, and a disconnected output stays low.

Other behaviour only the bench scenarios can show:
- The measured period length and high time for each mode and output polarity.
- The effect of a compare value above TOP.
- The deferred use of a compare value written in the middle of a period.
- The long excursion to 0xFFFF after the period register is lowered below the count.

// File: rtl/pwm_slope_pkg.sv
package pwm_slope_pkg;
  localparam int CNT_W = 16;

  localparam logic [3:0] MODE_FIX8  = 4'd5;
  localparam logic [3:0] MODE_FIX9  = 4'd6;
  localparam logic [3:0] MODE_FIX10 = 4'd7;
  localparam logic [3:0] MODE_PER   = 4'd14;
  localparam logic [3:0] MODE_CMPA  = 4'd15;

  localparam logic [CNT_W-1:0] TOP_FIX8  = 16'h00FF;
  localparam logic [CNT_W-1:0] TOP_FIX9  = 16'h01FF;
  localparam logic [CNT_W-1:0] TOP_FIX10 = 16'h03FF;

  // output mode codes: bit 1 enables the pin, bit 0 selects inversion
  localparam logic [1:0] OM_NONINV = 2'd2;
  localparam logic [1:0] OM_INV    = 2'd3;
endpackage

// File: rtl/pwm_top_select.sv
module pwm_top_select
  import pwm_slope_pkg::*;
(
  input  logic [3:0]       mode_sel,
  input  logic [CNT_W-1:0] period_q,
  input  logic [CNT_W-1:0] cmpa_act,
  output logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] wr_mask
);
  always_comb begin
    top_val = '1;
    wr_mask = '1;
    case (mode_sel)
      MODE_FIX8:  begin top_val = TOP_FIX8;  wr_mask = TOP_FIX8;  end
      MODE_FIX9:  begin top_val = TOP_FIX9;  wr_mask = TOP_FIX9;  end
      MODE_FIX10: begin top_val = TOP_FIX10; wr_mask = TOP_FIX10; end
      MODE_PER:   top_val = period_q;
      MODE_CMPA:  top_val = cmpa_act;
      default:    top_val = '1;  // unlisted codes run the full 16-bit range
    endcase
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_slope_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             at_top
);
  logic [CNT_W-1:0] cnt_d;

  assign at_top = (cnt_q == top_val);

  always_comb begin
    cnt_d = cnt_q;
    if (tick_en) begin
      if (at_top) cnt_d = '0;
      else        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_wrap_at_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && at_top) |=> (cnt_q == '0));
  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !at_top) |=> (cnt_q == ($past(cnt_q) + 16'd1)));
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
  import pwm_slope_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             at_top,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             wr_stb,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] wr_mask,
  input  logic [1:0]       out_mode,
  output logic [CNT_W-1:0] cmp_act,
  output logic             match_o,
  output logic             pwm_q
);
  logic [CNT_W-1:0] cmp_buf_q, cmp_buf_d, cmp_act_d;
  logic             pwm_d;

  assign match_o = tick_en && (cnt_q == cmp_act);

  always_comb begin
    cmp_buf_d = cmp_buf_q;
    if (wr_stb) cmp_buf_d = wr_data & wr_mask;
  end

  always_comb begin
    cmp_act_d = cmp_act;
    if (tick_en && at_top) cmp_act_d = cmp_buf_q;
  end

  // level leaving TOP is the BOTTOM level; a match flips to the other level
  always_comb begin
    pwm_d = pwm_q;
    if (!out_mode[1])          pwm_d = 1'b0;
    else if (tick_en) begin
      if (at_top)              pwm_d = ~out_mode[0];
      else if (match_o)        pwm_d = out_mode[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_buf_q <= '0;
      cmp_act   <= '0;
      pwm_q     <= 1'b0;
    end else begin
      cmp_buf_q <= cmp_buf_d;
      cmp_act   <= cmp_act_d;
      pwm_q     <= pwm_d;
    end
  end

  assert_active_moves_at_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_en && at_top) |=> $stable(cmp_act));
  assert_write_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> ((cmp_buf_q & ~$past(wr_mask)) == '0));
  assert_off_pin_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_mode[1] |=> !pwm_q);
endmodule

// File: rtl/pwm_flag_bank.sv
module pwm_flag_bank #(
  parameter int FLAG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_vec,
  input  logic [FLAG_W-1:0] clr_vec,
  output logic [FLAG_W-1:0] flags_q
);
  logic [FLAG_W-1:0] flags_d;

  always_comb flags_d = (flags_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assert_set_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((flags_q & $past(clr_vec & ~set_vec)) == '0));
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec == '0) && (clr_vec == '0)) |=> $stable(flags_q));
endmodule

// File: rtl/pwm_slope_timer.sv
module pwm_slope_timer
  import pwm_slope_pkg::*;
#(
  parameter  int NCH    = 3,
  localparam int ADDR_W = $clog2(NCH + 1),
  localparam int FLAG_W = NCH + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [3:0]        mode_sel,
  input  logic [2*NCH-1:0]  out_mode,
  input  logic [FLAG_W-1:0] flag_clr,
  output logic [15:0]       count_out,
  output logic [FLAG_W-1:0] flags,
  output logic [NCH-1:0]    pwm_out
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] top_val, wr_mask, cnt_q;
  logic             at_top;
  logic [CNT_W-1:0] cmp_act [NCH];
  logic [NCH-1:0]   match;
  logic [FLAG_W-1:0] set_vec;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // period register: no shadow, used the cycle after the write
  always_comb begin
    period_d = period_q;
    if (wr_en && (wr_addr == '0)) period_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) period_q <= '0;
    else            period_q <= period_d;
  end

  pwm_top_select u_top_sel (
    .mode_sel (mode_sel),
    .period_q (period_q),
    .cmpa_act (cmp_act[0]),
    .top_val  (top_val),
    .wr_mask  (wr_mask)
  );

  pwm_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_en (tick_en),
    .top_val (top_val),
    .cnt_q   (cnt_q),
    .at_top  (at_top)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    pwm_cmp_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .tick_en  (tick_en),
      .at_top   (at_top),
      .cnt_q    (cnt_q),
      .wr_stb   (wr_en && (wr_addr == ADDR_W'(k + 1))),
      .wr_data  (wr_data),
      .wr_mask  (wr_mask),
      .out_mode (out_mode[2*k +: 2]),
      .cmp_act  (cmp_act[k]),
      .match_o  (match[k]),
      .pwm_q    (pwm_out[k])
    );
  end

  assign set_vec = {match, tick_en && at_top && (mode_sel == MODE_PER), tick_en && at_top};

  pwm_flag_bank #(.FLAG_W(FLAG_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_vec (set_vec),
    .clr_vec (flag_clr),
    .flags_q (flags)
  );

  assign count_out = cnt_q;

  assert_period_flag_with_ovf_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tick_en && at_top && (mode_sel == MODE_PER)) |=> (flags[0] && flags[1]));
  assert_cmpa_flag_with_ovf_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tick_en && at_top && (mode_sel == MODE_CMPA)) |=> (flags[0] && flags[2]));
  assert_period_write_now_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && (wr_addr == '0)) |=> (period_q == $past(wr_data)));
endmodule

// File: tb/pwm_slope_timer_bench.sv
`timescale 1ns/1ps
module pwm_slope_timer_bench;
  localparam int NCH = 3;
  localparam int FW  = NCH + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0] mode_sel = 4'd5;
  logic [2*NCH-1:0] out_mode = '0;
  logic [FW-1:0] flag_clr = '0;
  logic [15:0] count_out;
  logic [FW-1:0] flags;
  logic [NCH-1:0] pwm_out;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  pwm_slope_timer #(.NCH(NCH)) u_pwm_slope_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_sel(mode_sel), .out_mode(out_mode), .flag_clr(flag_clr),
    .count_out(count_out), .flags(flags), .pwm_out(pwm_out));

  // vector: mode, period, compare A, compare B, channel B output mode
  localparam int NV = 7;
  localparam logic [53:0] VEC [NV] = '{
    {4'd5,  16'h0000, 16'h0080, 16'h1F40, 2'd2},
    {4'd6,  16'h0000, 16'h0000, 16'h0100, 2'd3},
    {4'd7,  16'h0000, 16'h0000, 16'h0200, 2'd2},
    {4'd14, 16'h0063, 16'h0000, 16'h0031, 2'd2},
    {4'd15, 16'h0000, 16'h0031, 16'h0040, 2'd2},
    {4'd14, 16'h0003, 16'h0000, 16'h0001, 2'd3},
    {4'd15, 16'h0000, 16'h00C7, 16'h0000, 2'd2}
  };

  function automatic logic [15:0] mask_of(input logic [3:0] m);
    case (m)
      4'd5: return 16'h00FF;
      4'd6: return 16'h01FF;
      4'd7: return 16'h03FF;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [15:0] top_of(input logic [3:0] m, input logic [15:0] p, input logic [15:0] a);
    if (m == 4'd14) return p;
    if (m == 4'd15) return a;
    return mask_of(m);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    int g = 0;
    while (count_out != v && g < 80000) begin @(negedge clk); g++; end
  endtask

  task automatic wait_ovf();
    int g = 0;
    while (!flags[0] && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic setup(input logic [3:0] m, input logic [15:0] p, input logic [15:0] a,
                       input logic [15:0] b, input logic [1:0] omb);
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0; mode_sel = m; out_mode = {2'd0, omb, 2'd0};
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    wr(2'd0, p); wr(2'd1, a); wr(2'd2, b);
    tick_en = 1'b1;
    wait_ovf();
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(count_out == 0, "R10 count after reset", count_out, 0);
    chk(flags == 0, "R10 flags after reset", flags, 0);
    chk(pwm_out == 0, "R10 outputs after reset", pwm_out, 0);

    // vector table: period length, high time, flags (R1 R3 R6 R7 R8)
    for (int v = 0; v < NV; v++) begin
      logic [3:0] m; logic [15:0] p, a, b, bt, tp; logic [1:0] om;
      int n, hi, exp_hi;
      {m, p, a, b, om} = VEC[v];
      setup(m, p, a, b, om);
      bt = b & mask_of(m);
      tp = top_of(m, p, a & mask_of(m));
      flag_clr = '1;
      n = 0; hi = 0;
      do begin
        n++; hi += int'(pwm_out[1]);
        @(negedge clk);
        flag_clr = '0;
      end while (!flags[0] && n < 5000);
      exp_hi = (bt >= tp) ? int'(tp) + 1 : int'(bt) + 1;
      if (om == 2'd3) exp_hi = int'(tp) + 1 - exp_hi;
      chk(n == int'(tp) + 1, "R1 period length", n, int'(tp) + 1);
      chk(hi == exp_hi, "R8 R6 high time", hi, exp_hi);
      chk(flags[1] == (m == 4'd14), "R3 period match flag", flags[1], (m == 4'd14));
      chk(flags[3] == (bt <= tp), "R7 channel B flag", flags[3], (bt <= tp));
      chk(pwm_out[0] == 1'b0 && pwm_out[2] == 1'b0, "R8 disconnected pins", pwm_out, pwm_out & 3'b010);
    end

    // R5: a compare written mid-period waits for TOP
    setup(4'd14, 16'd99, 16'd0, 16'd49, 2'd2);
    wait_cnt(16'd10);
    wr(2'd2, 16'd80);
    wait_cnt(16'd60);
    chk(pwm_out[1] == 1'b0, "R5 old compare still active", pwm_out[1], 0);
    wait_cnt(16'd0);
    wait_cnt(16'd60);
    chk(pwm_out[1] == 1'b1, "R5 new compare after TOP", pwm_out[1], 1);

    // R2 and R9: tick enable gating and write-one-to-clear
    begin
      logic [15:0] c0; logic [FW-1:0] f0;
      wait_cnt(16'd30);
      tick_en = 1'b0;
      @(negedge clk);
      c0 = count_out; f0 = flags;
      repeat (10) @(negedge clk);
      chk(count_out == c0, "R2 count holds without tick", count_out, c0);
      chk(flags == f0, "R2 flags hold without tick", flags, f0);
      flag_clr = 5'b00001;
      @(negedge clk);
      flag_clr = '0;
      chk(flags == (f0 & 5'b11110), "R9 clear only overflow bit", flags, f0 & 5'b11110);
      tick_en = 1'b1;
    end

    // R4: period lowered below the count
    setup(4'd14, 16'd999, 16'd0, 16'd0, 2'd0);
    wait_cnt(16'd50);
    wr(2'd0, 16'd10);
    repeat (20) @(negedge clk);
    chk(count_out > 16'd10, "R4 count runs past new TOP", count_out, 16'd71);
    flag_clr = '1;
    @(negedge clk);
    flag_clr = '0;
    wait_cnt(16'hFFFF);
    chk(count_out == 16'hFFFF, "R4 count reaches 0xFFFF", count_out, 16'hFFFF);
    @(negedge clk);
    chk(count_out == 0 && flags[0] == 1'b0, "R4 wrap without overflow flag", {flags[0], count_out}, 0);
    wait_cnt(16'd10);
    @(negedge clk);
    chk(flags[0] == 1'b1 && count_out == 0, "R4 new TOP in effect", {flags[0], count_out}, 17'h10000);

    // R10: asynchronous reset in the middle of a run
    wait_cnt(16'd5);
    rst_n = 1'b0;
    #1;
    chk(count_out == 0 && flags == 0, "R10 reset mid-run", {flags, count_out}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    finish_run();
  end
endmodule